// File: doc/BRIEF.md
# Multi-Source Reset Controller with Sticky Cause Flags

This block merges five reset requests into a single active-low internal reset: a supply power-on detector, a fixed low-voltage channel (channel 0), two programmable low-voltage monitor channels, and an active-low external reset pin. The analog comparators sit outside the block. Each one arrives as a digital level that is high while the supply is at or below its threshold.

Any request pulls the internal reset low at once, without waiting for a clock edge. Release goes through a shared down-counter and then a two-flop synchronizer. The counter's reload value depends on which source was active. Each programmable monitor channel has an enable bit and a mode bit. With the mode bit at 1, a low-voltage event raises a reset. With the mode bit at 0, it raises a one-cycle interrupt pulse instead.

Channel 0 is enabled by a configuration bit. That bit is captured only while the power-on detector is active. Every source has a sticky cause flag. Only a power-on event clears all flags. Software clears the others by writing 1 to the matching bit of the clear input.

Top module: `reset_cause_ctrl`

## Requirements
- R1: While `por_low_i` is 1, `rst_n_o` is 0, and one clock edge later `cause_o` reads 5'b00001, with every other flag cleared. Flag bit order: 0 power-on, 1 channel 0, 2 monitor 1, 3 monitor 2, 4 pin.
- R2: Let the last clock edge that sampled a source high be edge 0. `rst_n_o` rises on rising edge T+2 after edge 0, where T is the reload value for that source. For power-on, T is `T_POR`.
- R3: If the latched channel-0 enable is 1, `ch0_low_i`=1 asserts the reset and sets flag bit 1, and release uses T=`T_CH0`. The enable is taken from `ch0_cfg_i` on every edge at which `por_low_i` is 1.
- R4: If `ch0_cfg_i` was 0 during the last power-on, `ch0_low_i` has no effect on `rst_n_o` or `cause_o`, even if `ch0_cfg_i` changes later.
- R5: Monitor channel n (n=0 or 1) asserts the reset when `mon_en_i[n]`, `mon_mode_i[n]` and `mon_low_i[n]` are all 1. It sets flag bit 2+n, and release uses T=`T_MON`.
- R6: With `mon_en_i[n]`=0, `mon_low_i[n]` produces no reset, no interrupt and no flag.
- R7: With `mon_en_i[n]`=1 and `mon_mode_i[n]`=0, a rise of the channel's event makes `mon_irq_o[n]` high for exactly one cycle, on the edge after the event appears. No reset results and no flag is set.
- R8: `ext_rst_n_i`=0 asserts the reset and sets flag bit 4, and release uses T=`T_PIN`.
- R9: Assertion is asynchronous. `rst_n_o` goes low as soon as any request appears, before the next clock edge.
- R10: Flags persist across resets from sources other than power-on. Writing `flag_clr_i[i]`=1 clears flag i on the next edge, but an active request for source i in the same cycle wins and keeps the flag set.
- R11: The counter reloads on every edge at which any request is present, so a request that re-asserts during the stretch restarts the count. When several sources request together, the reload is chosen in priority order: power-on, then channel 0, then monitors, then pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running clock |
| por_low_i | input | 1 | Supply below power-on level |
| ch0_cfg_i | input | 1 | Channel-0 enable option, captured during power-on |
| ch0_low_i | input | 1 | Supply at or below channel-0 threshold |
| mon_en_i | input | N_MON | Monitor channel enable bits |
| mon_mode_i | input | N_MON | Monitor mode: 1 selects reset, 0 selects interrupt |
| mon_low_i | input | N_MON | Supply at or below monitor threshold |
| ext_rst_n_i | input | 1 | External reset pin, active low |
| flag_clr_i | input | N_MON+3 | Write-1-to-clear strobes for the cause flags |
| rst_n_o | output | 1 | Internal reset, active low |
| mon_irq_o | output | N_MON | One-cycle interrupt pulse per monitor channel |
| cause_o | output | N_MON+3 | Sticky reset-cause flags |

## Verification
Each source is driven on its own, so that release after T_POR, T_CH0, T_MON and T_PIN cycles separates the reload values and the flag bit identifies the source. Monitor channels are exercised in three settings:
- disabled,
- interrupt mode, where a pulse must appear with no reset,
- reset mode.
This separates the decoding of the enable bit from that of the mode bit. Re-asserting a source in the middle of the stretch, and asserting two sources at once, shows whether the counter reloads and which source wins the priority. Clearing a flag in the same cycle as an active request, and running a second power-on with the option bit at 0, tell the sticky, set-wins and power-up-capture behaviours apart.

// File: rtl/rcc_pkg.sv
package rcc_pkg;
  localparam int unsigned SRC_POR = 0;
  localparam int unsigned SRC_CH0 = 1;
  localparam int unsigned SRC_MON0 = 2;

  function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/rcc_mon_chan.sv
module rcc_mon_chan (
  input  logic clk_i,
  input  logic por_i,
  input  logic en_i,
  input  logic mode_i,
  input  logic low_i,
  output logic rst_req_o,
  output logic irq_o
);
  logic ev;
  logic ev_q;
  logic irq_q;

  assign rst_req_o = en_i & mode_i & low_i;
  assign ev        = en_i & ~mode_i & low_i;

  always_ff @(posedge clk_i) begin
    if (por_i) begin
      ev_q  <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      ev_q  <= ev;
      irq_q <= ev & ~ev_q;
    end
  end

  assign irq_o = irq_q;

  // R7
  irq_single_chk: assert property (@(posedge clk_i) disable iff (por_i)
    irq_o |=> !irq_o);

  // R6
  irq_off_chk: assert property (@(posedge clk_i) disable iff (por_i)
    !en_i |=> !irq_o);
endmodule

// File: rtl/rcc_stretch.sv
module rcc_stretch #(
  parameter int unsigned N_MON = 2,
  parameter int unsigned T_POR = 20,
  parameter int unsigned T_CH0 = 12,
  parameter int unsigned T_MON = 6,
  parameter int unsigned T_PIN = 3,
  localparam int unsigned NSRC = N_MON + 3,
  localparam int unsigned T_MAX = rcc_pkg::max_of(rcc_pkg::max_of(T_POR, T_CH0),
                                                  rcc_pkg::max_of(T_MON, T_PIN)),
  localparam int unsigned CW = $clog2(T_MAX + 1) + 1
) (
  input  logic            clk_i,
  input  logic [NSRC-1:0] req_i,
  output logic            rst_n_o
);
  logic          any_req;
  logic          hold;
  logic [CW-1:0] reload;
  logic [CW-1:0] cnt_q;
  logic [1:0]    sync_q;

  assign any_req = |req_i;

  always_comb begin
    reload = CW'(T_PIN);
    if (|req_i[N_MON+1:2]) reload = CW'(T_MON);
    if (req_i[1])          reload = CW'(T_CH0);
    if (req_i[0])          reload = CW'(T_POR);
  end

  always_ff @(posedge clk_i) begin
    if (any_req)
      cnt_q <= reload;
    else if (cnt_q != '0)
      cnt_q <= cnt_q - 1'b1;
  end

  assign hold = any_req | (cnt_q != '0);

  always_ff @(posedge clk_i or posedge hold) begin
    if (hold)
      sync_q <= 2'b00;
    else
      sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];

  // R9
  src_hold_chk: assert property (@(posedge clk_i) disable iff (req_i[0])
    any_req |-> !rst_n_o);

  // R11
  count_down_chk: assert property (@(posedge clk_i) disable iff (req_i[0])
    (!any_req && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

  // R2
  release_sync_chk: assert property (@(posedge clk_i) disable iff (req_i[0])
    $rose(rst_n_o) |-> (!hold && $past(!hold)));
endmodule

// File: rtl/rcc_cause_flags.sv
module rcc_cause_flags #(
  parameter int unsigned NSRC = 5
) (
  input  logic            clk_i,
  input  logic [NSRC-1:0] req_i,
  input  logic [NSRC-1:0] clr_i,
  output logic [NSRC-1:0] cause_o
);
  logic [NSRC-1:0] flags_q;

  always_ff @(posedge clk_i) begin
    if (req_i[rcc_pkg::SRC_POR])
      flags_q <= NSRC'(1) << rcc_pkg::SRC_POR;
    else
      flags_q <= (flags_q & ~clr_i) | req_i;
  end

  assign cause_o = flags_q;

  // R10
  sticky_flag_chk: assert property (@(posedge clk_i) disable iff (req_i[0])
    (|(cause_o & ~clr_i)) |=>
      ((cause_o & $past(cause_o & ~clr_i)) == $past(cause_o & ~clr_i)));

  // R10
  set_wins_chk: assert property (@(posedge clk_i) disable iff (req_i[0])
    (|req_i) |=> ((cause_o & $past(req_i)) == $past(req_i)));
endmodule

// File: rtl/reset_cause_ctrl.sv
module reset_cause_ctrl #(
  parameter int unsigned N_MON = 2,
  parameter int unsigned T_POR = 20,
  parameter int unsigned T_CH0 = 12,
  parameter int unsigned T_MON = 6,
  parameter int unsigned T_PIN = 3,
  localparam int unsigned NSRC = N_MON + 3
) (
  input  logic             clk_i,
  input  logic             por_low_i,
  input  logic             ch0_cfg_i,
  input  logic             ch0_low_i,
  input  logic [N_MON-1:0] mon_en_i,
  input  logic [N_MON-1:0] mon_mode_i,
  input  logic [N_MON-1:0] mon_low_i,
  input  logic             ext_rst_n_i,
  input  logic [NSRC-1:0]  flag_clr_i,
  output logic             rst_n_o,
  output logic [N_MON-1:0] mon_irq_o,
  output logic [NSRC-1:0]  cause_o
);
  logic             ch0_en_q;
  logic [N_MON-1:0] mon_req;
  logic [NSRC-1:0]  req;

  always_ff @(posedge clk_i) begin
    if (por_low_i) ch0_en_q <= ch0_cfg_i;
  end

  for (genvar g = 0; g < N_MON; g++) begin : g_mon
    rcc_mon_chan u_chan (
      .clk_i     (clk_i),
      .por_i     (por_low_i),
      .en_i      (mon_en_i[g]),
      .mode_i    (mon_mode_i[g]),
      .low_i     (mon_low_i[g]),
      .rst_req_o (mon_req[g]),
      .irq_o     (mon_irq_o[g])
    );
  end

  assign req = {~ext_rst_n_i, mon_req, ch0_low_i & ch0_en_q, por_low_i};

  rcc_stretch #(
    .N_MON (N_MON),
    .T_POR (T_POR),
    .T_CH0 (T_CH0),
    .T_MON (T_MON),
    .T_PIN (T_PIN)
  ) u_stretch (
    .clk_i   (clk_i),
    .req_i   (req),
    .rst_n_o (rst_n_o)
  );

  rcc_cause_flags #(
    .NSRC (NSRC)
  ) u_flags (
    .clk_i   (clk_i),
    .req_i   (req),
    .clr_i   (flag_clr_i),
    .cause_o (cause_o)
  );

  // R4
  ch0_masked_chk: assert property (@(posedge clk_i) disable iff (por_low_i)
    (!ch0_en_q && cause_o[1] == 1'b0 && !flag_clr_i[1]) |=> !cause_o[1]);
endmodule

// File: tb/reset_cause_ctrl_bench.sv
module reset_cause_ctrl_bench;
  localparam int unsigned NM = 2;
  localparam int unsigned NS = NM + 3;
  localparam int unsigned TP = 20;
  localparam int unsigned T0 = 12;
  localparam int unsigned TM = 6;
  localparam int unsigned TX = 3;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          por_low = 1'b1, ch0_cfg = 1'b1, ch0_low = 1'b0, ext_n = 1'b1;
  logic [NM-1:0] m_en = '0, m_mode = '0, m_low = '0;
  logic [NS-1:0] clr = '0;
  logic          rst_n;
  logic [NM-1:0] irq;
  logic [NS-1:0] cause;

  reset_cause_ctrl #(.N_MON(NM), .T_POR(TP), .T_CH0(T0), .T_MON(TM), .T_PIN(TX)) u_reset_cause_ctrl (
    .clk_i(clk), .por_low_i(por_low), .ch0_cfg_i(ch0_cfg), .ch0_low_i(ch0_low),
    .mon_en_i(m_en), .mon_mode_i(m_mode), .mon_low_i(m_low), .ext_rst_n_i(ext_n),
    .flag_clr_i(clr), .rst_n_o(rst_n), .mon_irq_o(irq), .cause_o(cause));

  typedef struct {
    logic          rst;
    logic [NS-1:0] cause;
    logic [NM-1:0] irq;
    string         tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  // monitor: one expected item per cycle, sampled 2 ns after the rising edge
  initial forever begin
    @(posedge clk);
    #2;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (rst_n !== e.rst || cause !== e.cause || irq !== e.irq) begin
        errors++;
        $display("FAIL %s: rst_n=%b cause=%b irq=%b expected rst_n=%b cause=%b irq=%b",
                 e.tag, rst_n, cause, irq, e.rst, e.cause, e.irq);
      end
    end
  end

  task automatic step(input logic r, input logic [NS-1:0] c, input logic [NM-1:0] i, input string tag);
    exp_t e;
    e.rst = r; e.cause = c; e.irq = i; e.tag = tag;
    q.push_back(e);
    @(negedge clk);
  endtask

  task automatic rel(input int from, input int t, input logic [NS-1:0] c, input string tag);
    for (int k = from; k <= t + 2; k++) step(k == t + 2, c, 2'b00, tag);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=complete");
      finish_run();
    end
  end

  initial begin
    // R1 power-on hold and flag
    for (int k = 0; k < 3; k++) step(0, 5'b00001, 2'b00, "R1");
    por_low = 1'b0;
    rel(1, TP, 5'b00001, "R2");
    // R3 channel 0 enabled by option captured at power-on
    ch0_cfg = 1'b0;
    ch0_low = 1'b1;
    step(0, 5'b00011, 2'b00, "R3");
    ch0_low = 1'b0;
    rel(1, T0, 5'b00011, "R3");
    // R10 clear
    clr = 5'b00011;
    step(1, 5'b00000, 2'b00, "R10 clear");
    clr = '0;
    // R5 monitor 1 in reset mode
    m_en[0] = 1'b1; m_mode[0] = 1'b1; m_low[0] = 1'b1;
    step(0, 5'b00100, 2'b00, "R5");
    m_low[0] = 1'b0;
    rel(1, TM, 5'b00100, "R5");
    // R6 monitor 2 disabled
    m_mode[1] = 1'b1; m_low[1] = 1'b1;
    for (int k = 0; k < 3; k++) step(1, 5'b00100, 2'b00, "R6");
    m_low[1] = 1'b0;
    // R7 interrupt mode, both channels
    m_en[1] = 1'b1; m_mode[1] = 1'b0; m_low[1] = 1'b1;
    step(1, 5'b00100, 2'b10, "R7 pulse");
    step(1, 5'b00100, 2'b00, "R7 single");
    m_low[1] = 1'b0;
    step(1, 5'b00100, 2'b00, "R7");
    m_mode[0] = 1'b0; m_low[0] = 1'b1;
    step(1, 5'b00100, 2'b01, "R7 pulse");
    step(1, 5'b00100, 2'b00, "R7 single");
    m_low[0] = 1'b0; m_mode[0] = 1'b1;
    step(1, 5'b00100, 2'b00, "R7");
    // R8 pin, R9 asynchronous assertion
    ext_n = 1'b0;
    #1;
    checks++;
    if (rst_n !== 1'b0) begin
      errors++;
      $display("FAIL R9: rst_n=%b expected 0 before clock edge", rst_n);
    end
    step(0, 5'b10100, 2'b00, "R8");
    ext_n = 1'b1;
    rel(1, TX, 5'b10100, "R8");
    step(1, 5'b10100, 2'b00, "R10 survives");
    // R10 set wins over clear
    ext_n = 1'b0; clr = 5'b10000;
    step(0, 5'b10100, 2'b00, "R10 set wins");
    ext_n = 1'b1;
    step(0, 5'b00100, 2'b00, "R10 cleared");
    clr = '0;
    rel(2, TX, 5'b00100, "R8");
    // R4 second power-on with option 0
    por_low = 1'b1; ch0_cfg = 1'b0;
    step(0, 5'b00001, 2'b00, "R1 clears");
    step(0, 5'b00001, 2'b00, "R1");
    por_low = 1'b0;
    rel(1, TP, 5'b00001, "R2");
    ch0_cfg = 1'b1; ch0_low = 1'b1;
    for (int k = 0; k < 3; k++) step(1, 5'b00001, 2'b00, "R4");
    ch0_low = 1'b0;
    // R11 restart during stretch
    m_low[0] = 1'b1;
    step(0, 5'b00101, 2'b00, "R11");
    m_low[0] = 1'b0;
    for (int k = 0; k < 3; k++) step(0, 5'b00101, 2'b00, "R11");
    m_low[0] = 1'b1;
    step(0, 5'b00101, 2'b00, "R11");
    m_low[0] = 1'b0;
    rel(1, TM, 5'b00101, "R11 restart");
    // R11 priority: monitor over pin
    m_low[0] = 1'b1; ext_n = 1'b0;
    step(0, 5'b10101, 2'b00, "R11");
    m_low[0] = 1'b0; ext_n = 1'b1;
    rel(1, TM, 5'b10101, "R11 priority");
    wait (q.size() == 0);
    @(negedge clk);
    done = 1;
    finish_run();
  end
endmodule